// File: doc/BRIEF.md
# SPI FIFO and Event Unit

This unit sits between a simple register bus and a serial shift engine. It buffers outgoing bytes in a 32-byte transmit queue and incoming bytes in a 32-byte receive queue. Software reaches each queue through a single data register that accepts byte, halfword or word accesses. A multi-byte access moves its bytes most significant first, so one word write queues four bytes and one word read takes up to four.

The shift engine sees only a byte handshake. It pops one transmit byte per cycle, pushes one receive byte per cycle, and pulses a done strobe when a transfer ends. A control register holds an enable bit, an internal loopback bit and two fill thresholds. The status register reports both fill counts, a set of latched and live flags and a sticky overrun flag. Latched flags are cleared by writing ones to them. A mask register selects which flags drive the single interrupt line.

Register selection uses `bus_reg`: 0 control, 1 status/event, 2 interrupt mask, 3 transmit data, 4 receive data. Access size uses `bus_size`: 0 byte, 1 halfword, 2 or 3 word. Control, mask and event writes always take the whole word.

Top module: `spi_buf_evt`

## Requirements
- R1: After reset the control register reads 0x0000_040F (enable bit 31 = 0, loopback bit 30 = 0, transmit threshold in bits 13:8 = 4, receive threshold in bits 5:0 = 15). The transmit free count is 32, the receive count is 0, the mask is 0 and `irq` is low.
- R2: Transmit writes queue bytes most significant first. A word queues bits 31:24, 23:16, 15:8 and 7:0 in that order, a halfword queues bits 15:8 then 7:0, and a byte queues bits 7:0. The engine receives the bytes in exactly that order on `eng_tx_byte`.
- R3: A transmit write whose size exceeds the free space is dropped whole. The free count does not change, and the sticky overrun flag (event bit 10) sets.
- R4: A receive read of size n removes min(n, stored) bytes. The oldest byte sits in the highest byte of the access width, and byte positions with no stored data read as zero.
- R5: The event register shows the receive count in bits 29:24 and the free transmit space in bits 21:16. Bit 9 (receive not empty) and bit 8 (transmit not full) follow the current state. The `tx_free` and `rx_level` ports carry the same two counts.
- R6: Bits 15 (transmit empty), 13 (receive threshold), 12 (receive full) and 11 (transmit threshold) latch on the rising edge of their condition. Writing ones to bits 15:10 clears those bits, and writing all ones clears them all. If a set and a clear of the same bit fall in the same cycle, the set wins.
- R7: The receive threshold condition is receive count > receive threshold. The transmit threshold condition is free count >= transmit threshold.
- R8: `irq` is the OR over event bits 15:8 of each bit ANDed with the matching mask bit (mask register bits 15:8).
- R9: While the enable bit is clear, `eng_tx_valid` stays low and engine pops and pushes have no effect. Bus accesses to both queues still work.
- R10: With loopback set, each byte the engine pops from the transmit queue enters the receive queue, and the external receive push is ignored.
- R11: A receive push arriving while the receive queue holds 32 bytes is dropped and sets the overrun flag (bit 10).
- R12: A pulse on `eng_done` latches event bit 14.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops the receive queue) |
| bus_reg | input | 3 | Register select |
| bus_size | input | 2 | Access size: 0 byte, 1 halfword, 2/3 word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the selected register |
| eng_tx_valid | output | 1 | Transmit byte available to the engine |
| eng_tx_byte | output | 8 | Oldest transmit byte |
| eng_tx_pop | input | 1 | Engine takes the transmit byte |
| eng_rx_push | input | 1 | Engine delivers a received byte |
| eng_rx_byte | input | 8 | Received byte |
| eng_done | input | 1 | Transfer-done pulse |
| tx_free | output | 6 | Free bytes in the transmit queue |
| rx_level | output | 6 | Bytes stored in the receive queue |
| irq | output | 1 | Masked interrupt |

## Verification
A corrupted read or write pointer shows up at the engine's byte stream, or in the bytes a receive read returns, on the first byte that passes through the damaged slot. A wrong count is visible in the same cycle on `tx_free` or `rx_level`. A wrong edge detector shows in the event word, and through `irq`, one cycle after the condition changes: a flag either appears without a new edge or fails to reappear after a clear. The bench therefore tracks every queued byte, and it compares the counts and event word after each step.

// File: rtl/sbe_pkg.sv
package sbe_pkg;
   localparam logic [2:0] RI_MODE  = 3'd0;
   localparam logic [2:0] RI_EVENT = 3'd1;
   localparam logic [2:0] RI_MASK  = 3'd2;
   localparam logic [2:0] RI_TXD   = 3'd3;
   localparam logic [2:0] RI_RXD   = 3'd4;

   localparam logic [1:0] SZ_BYTE = 2'd0;
   localparam logic [1:0] SZ_HALF = 2'd1;

   // bytes moved by one access of the given size
   function automatic logic [2:0] size_bytes(input logic [1:0] sz);
      case (sz)
         SZ_BYTE: size_bytes = 3'd1;
         SZ_HALF: size_bytes = 3'd2;
         default: size_bytes = 3'd4;
      endcase
   endfunction
endpackage

// File: rtl/sbe_byte_fifo.sv
module sbe_byte_fifo #(
   parameter int DEPTH = 32,
   parameter int LANES = 4
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [$clog2(LANES+1)-1:0] push_n,
   input  logic [LANES*8-1:0]         push_data,
   input  logic [$clog2(LANES+1)-1:0] pop_n,
   output logic [LANES*8-1:0]         peek_data,
   output logic [$clog2(DEPTH+1)-1:0] count
);
   localparam int AW = $clog2(DEPTH);
   localparam int CW = $clog2(DEPTH+1);
   localparam int NW = $clog2(LANES+1);

   if ((DEPTH & (DEPTH-1)) != 0 || DEPTH < LANES) begin : g_bad_depth
      $error("sbe_byte_fifo: DEPTH must be a power of two not below LANES");
   end

   logic [7:0]    mem [DEPTH];
   logic [AW-1:0] wr_ptr, rd_ptr;

   always_ff @(posedge clk) begin
      for (int i = 0; i < LANES; i++) begin
         if (NW'(i) < push_n) mem[wr_ptr + AW'(i)] <= push_data[i*8 +: 8];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         wr_ptr <= wr_ptr + AW'(push_n);
         rd_ptr <= rd_ptr + AW'(pop_n);
         count  <= count + CW'(push_n) - CW'(pop_n);
      end
   end

   for (genvar g = 0; g < LANES; g++) begin : g_peek
      assign peek_data[g*8 +: 8] = (CW'(g) < count) ? mem[rd_ptr + AW'(g)] : 8'h00;
   end
endmodule

// File: rtl/sbe_evt_ctl.sv
module sbe_evt_ctl #(
   parameter int DEPTH = 32,
   parameter int CW    = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [CW-1:0] tx_free,
   input  logic [CW-1:0] rx_cnt,
   input  logic [5:0]    tx_thr,
   input  logic [5:0]    rx_thr,
   input  logic          ovr_pulse,
   input  logic          done_pulse,
   input  logic          clr_en,
   input  logic [5:0]    clr_bits,
   input  logic [7:0]    mask,
   output logic [7:0]    flags,
   output logic          irq
);
   // level conditions, index: 0 tx thr, 1 rx full, 2 rx thr, 3 tx empty
   logic [3:0] lvl, lvl_q, rise;
   // latched bits, index k is event bit 10+k
   logic [5:0] lat, set_v;

   always_comb begin
      lvl[0] = 6'(tx_free) >= tx_thr;
      lvl[1] = rx_cnt == CW'(DEPTH);
      lvl[2] = 6'(rx_cnt) > rx_thr;
      lvl[3] = tx_free == CW'(DEPTH);
      rise   = lvl & ~lvl_q;
      set_v  = {rise[3], done_pulse, rise[2], rise[1], rise[0], ovr_pulse};
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lvl_q <= '0;
         lat   <= '0;
      end else begin
         lvl_q <= lvl;
         lat   <= (lat & ~(clr_en ? clr_bits : 6'h00)) | set_v;
      end
   end

   assign flags = {lat, rx_cnt != '0, tx_free != '0};
   assign irq   = |(flags & mask);
endmodule

// File: rtl/spi_buf_evt.sv
module spi_buf_evt
   import sbe_pkg::*;
#(
   parameter int          DEPTH      = 32,
   parameter int          BUS_W      = 32,
   parameter logic [5:0]  TX_THR_RST = 6'd4,
   parameter logic [5:0]  RX_THR_RST = 6'd15
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        bus_wr,
   input  logic        bus_rd,
   input  logic [2:0]  bus_reg,
   input  logic [1:0]  bus_size,
   input  logic [31:0] bus_wdata,
   output logic [31:0] bus_rdata,
   output logic        eng_tx_valid,
   output logic [7:0]  eng_tx_byte,
   input  logic        eng_tx_pop,
   input  logic        eng_rx_push,
   input  logic [7:0]  eng_rx_byte,
   input  logic        eng_done,
   output logic [5:0]  tx_free,
   output logic [5:0]  rx_level,
   output logic        irq
);
   localparam int LANES = BUS_W / 8;
   localparam int CW    = $clog2(DEPTH+1);
   localparam int NW    = $clog2(LANES+1);

   if (BUS_W != 32 || DEPTH < 4 || DEPTH > 32 || (DEPTH & (DEPTH-1)) != 0) begin : g_bad_cfg
      $error("spi_buf_evt: needs a 32-bit bus and a power-of-two DEPTH of 4..32");
   end

   logic             ctl_en, ctl_loop;
   logic [5:0]       tx_thr, rx_thr;
   logic [7:0]       irq_mask, evt_flags;
   logic [CW-1:0]    tx_cnt, rx_cnt, tx_free_w;
   logic [NW-1:0]    acc_n, tx_push_n, rx_pop_n, tx_pop_n, rx_push_n;
   logic [BUS_W-1:0] wr_al, rd_al, rx_rd_word, tx_push_data, rx_push_data;
   logic [BUS_W-1:0] tx_peek, rx_peek;
   logic             tx_wr, tx_fits, tx_ovr, rx_rd, tx_pop_ok;
   logic             rx_src_v, rx_full, rx_ovr;
   logic [7:0]       rx_src_b;

   assign acc_n     = NW'(size_bytes(bus_size));
   assign tx_free_w = CW'(DEPTH) - tx_cnt;

   // ---------------- transmit side ----------------
   assign tx_wr     = bus_wr && (bus_reg == RI_TXD);
   assign tx_fits   = tx_free_w >= CW'(acc_n);
   assign tx_push_n = (tx_wr && tx_fits) ? acc_n : '0;
   assign tx_ovr    = tx_wr && !tx_fits;
   assign wr_al     = bus_wdata << (8 * (LANES - int'(acc_n)));

   for (genvar g = 0; g < LANES; g++) begin : g_tx_lane
      assign tx_push_data[g*8 +: 8] = wr_al[BUS_W-1-g*8 -: 8];
   end

   assign tx_pop_ok    = ctl_en && eng_tx_pop && (tx_cnt != '0);
   assign tx_pop_n     = NW'(tx_pop_ok);
   assign eng_tx_valid = ctl_en && (tx_cnt != '0);
   assign eng_tx_byte  = tx_peek[7:0];

   sbe_byte_fifo #(.DEPTH(DEPTH), .LANES(LANES)) u_tx_fifo (
      .clk       (clk),
      .rst_n     (rst_n),
      .push_n    (tx_push_n),
      .push_data (tx_push_data),
      .pop_n     (tx_pop_n),
      .peek_data (tx_peek),
      .count     (tx_cnt)
   );

   // ---------------- receive side ----------------
   always_comb begin
      if (ctl_loop) begin
         rx_src_v = tx_pop_ok;
         rx_src_b = tx_peek[7:0];
      end else begin
         rx_src_v = ctl_en && eng_rx_push;
         rx_src_b = eng_rx_byte;
      end
   end

   assign rx_full      = rx_cnt == CW'(DEPTH);
   assign rx_push_n    = NW'(rx_src_v && !rx_full);
   assign rx_ovr       = rx_src_v && rx_full;
   assign rx_push_data = {{(BUS_W-8){1'b0}}, rx_src_b};
   assign rx_rd        = bus_rd && (bus_reg == RI_RXD);

   always_comb begin
      if (!rx_rd)                    rx_pop_n = '0;
      else if (rx_cnt >= CW'(acc_n)) rx_pop_n = acc_n;
      else                           rx_pop_n = NW'(rx_cnt);
   end

   for (genvar g = 0; g < LANES; g++) begin : g_rx_lane
      assign rd_al[BUS_W-1-g*8 -: 8] = rx_peek[g*8 +: 8];
   end
   assign rx_rd_word = rd_al >> (8 * (LANES - int'(acc_n)));

   sbe_byte_fifo #(.DEPTH(DEPTH), .LANES(LANES)) u_rx_fifo (
      .clk       (clk),
      .rst_n     (rst_n),
      .push_n    (rx_push_n),
      .push_data (rx_push_data),
      .pop_n     (rx_pop_n),
      .peek_data (rx_peek),
      .count     (rx_cnt)
   );

   // ---------------- control and mask ----------------
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctl_en   <= 1'b0;
         ctl_loop <= 1'b0;
         tx_thr   <= TX_THR_RST;
         rx_thr   <= RX_THR_RST;
         irq_mask <= '0;
      end else if (bus_wr) begin
         if (bus_reg == RI_MODE) begin
            ctl_en   <= bus_wdata[31];
            ctl_loop <= bus_wdata[30];
            tx_thr   <= bus_wdata[13:8];
            rx_thr   <= bus_wdata[5:0];
         end
         if (bus_reg == RI_MASK) irq_mask <= bus_wdata[15:8];
      end
   end

   sbe_evt_ctl #(.DEPTH(DEPTH), .CW(CW)) u_evt (
      .clk        (clk),
      .rst_n      (rst_n),
      .tx_free    (tx_free_w),
      .rx_cnt     (rx_cnt),
      .tx_thr     (tx_thr),
      .rx_thr     (rx_thr),
      .ovr_pulse  (tx_ovr || rx_ovr),
      .done_pulse (eng_done),
      .clr_en     (bus_wr && (bus_reg == RI_EVENT)),
      .clr_bits   (bus_wdata[15:10]),
      .mask       (irq_mask),
      .flags      (evt_flags),
      .irq        (irq)
   );

   assign tx_free  = 6'(tx_free_w);
   assign rx_level = 6'(rx_cnt);

   always_comb begin
      case (bus_reg)
         RI_MODE:  bus_rdata = {ctl_en, ctl_loop, 16'h0000, tx_thr, 2'b00, rx_thr};
         RI_EVENT: bus_rdata = {2'b00, rx_level, 2'b00, tx_free, evt_flags, 8'h00};
         RI_MASK:  bus_rdata = {16'h0000, irq_mask, 8'h00};
         RI_RXD:   bus_rdata = rx_rd_word;
         default:  bus_rdata = '0;
      endcase
   end
endmodule

// File: rtl/sbe_checker.sv
module sbe_checker #(
   parameter int DEPTH = 32
) (
   input logic        clk,
   input logic        rst_n,
   input logic        bus_wr,
   input logic [2:0]  bus_reg,
   input logic [1:0]  bus_size,
   input logic [31:0] bus_wdata,
   input logic        eng_tx_pop,
   input logic        eng_tx_valid,
   input logic        eng_done,
   input logic [5:0]  tx_free,
   input logic [5:0]  rx_level,
   input logic        irq,
   input logic [7:0]  flags,
   input logic        ctl_en
);
   logic short_word_wr;
   assign short_word_wr = bus_wr && (bus_reg == 3'd3) && bus_size[1] && (tx_free < 6'd4);

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (short_word_wr && !eng_tx_pop) |=> (tx_free == $past(tx_free))); // R3

   AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      short_word_wr |=> flags[2]); // R3

   AST_MASK_ZERO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && (bus_reg == 3'd2) && (bus_wdata[15:8] == 8'h00)) |=> !irq); // R8

   AST_DONE_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
      eng_done |=> flags[6]); // R12

   AST_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl_en |-> !eng_tx_valid); // R9

   AST_RX_ONE_PER_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (7'(rx_level) <= 7'($past(rx_level)) + 7'd1)); // R10

   AST_LEVEL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_free <= 6'(DEPTH)) && (rx_level <= 6'(DEPTH))); // R5
endmodule

bind spi_buf_evt sbe_checker #(.DEPTH(DEPTH)) u_sbe_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .bus_wr       (bus_wr),
   .bus_reg      (bus_reg),
   .bus_size     (bus_size),
   .bus_wdata    (bus_wdata),
   .eng_tx_pop   (eng_tx_pop),
   .eng_tx_valid (eng_tx_valid),
   .eng_done     (eng_done),
   .tx_free      (tx_free),
   .rx_level     (rx_level),
   .irq          (irq),
   .flags        (evt_flags),
   .ctl_en       (ctl_en)
);

// File: tb/tb_spi_buf_evt.sv
module tb_spi_buf_evt;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0, bus_rd = 1'b0;
   logic [2:0]  bus_reg = '0;
   logic [1:0]  bus_size = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        eng_tx_valid;
   logic [7:0]  eng_tx_byte;
   logic        eng_tx_pop = 1'b0, eng_rx_push = 1'b0, eng_done = 1'b0;
   logic [7:0]  eng_rx_byte = '0;
   logic [5:0]  tx_free, rx_level;
   logic        irq;

   int total = 0;
   int bad = 0;
   bit finished = 0;
   logic [7:0] exp_q[$];

   always #2 clk = ~clk;

   spi_buf_evt dut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_reg(bus_reg), .bus_size(bus_size), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .eng_tx_valid(eng_tx_valid), .eng_tx_byte(eng_tx_byte),
      .eng_tx_pop(eng_tx_pop), .eng_rx_push(eng_rx_push), .eng_rx_byte(eng_rx_byte),
      .eng_done(eng_done), .tx_free(tx_free), .rx_level(rx_level), .irq(irq)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic wr(input logic [2:0] r, input logic [1:0] s, input logic [31:0] d);
      bus_reg = r; bus_size = s; bus_wdata = d; bus_wr = 1'b1;
      tick();
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [2:0] r, input logic [1:0] s, output logic [31:0] d);
      tick();
      bus_reg = r; bus_size = s; bus_rd = 1'b1;
      @(negedge clk);
      d = bus_rdata;
      tick();
      bus_rd = 1'b0;
   endtask

   // driver: writes a transmit access and records the bytes it should queue
   task automatic tx_put(input logic [1:0] s, input logic [31:0] d, input bit accept);
      wr(3'd3, s, d);
      if (accept) begin
         if (s == 2'd0) exp_q.push_back(d[7:0]);
         else if (s == 2'd1) begin exp_q.push_back(d[15:8]); exp_q.push_back(d[7:0]); end
         else begin
            exp_q.push_back(d[31:24]); exp_q.push_back(d[23:16]);
            exp_q.push_back(d[15:8]);  exp_q.push_back(d[7:0]);
         end
      end
   endtask

   task automatic drain(input int n);
      eng_tx_pop = 1'b1;
      repeat (n) tick();
      eng_tx_pop = 1'b0;
   endtask

   task automatic rx_in(input logic [7:0] b);
      eng_rx_push = 1'b1; eng_rx_byte = b;
      tick();
      eng_rx_push = 1'b0;
   endtask

   task automatic see_port(input string req, input logic [31:0] act, input logic [31:0] exp);
      @(negedge clk);
      check(req, act, exp);
   endtask

   // monitor: every byte the engine takes must match the scoreboard head
   always @(negedge clk) begin
      if (eng_tx_pop && eng_tx_valid) begin
         total++;
         if (exp_q.size() == 0) begin
            bad++;
            $display("FAIL R2 actual=%h expected=<none>", eng_tx_byte);
         end else begin
            logic [7:0] e;
            e = exp_q.pop_front();
            if (eng_tx_byte !== e) begin
               bad++;
               $display("FAIL R2 actual=%h expected=%h", eng_tx_byte, e);
            end
         end
      end
   end

   initial begin
      logic [31:0] v;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1 reset state, R5/R6 initial event word
      rd(3'd0, 2'd2, v); check("R1 mode", v, 32'h0000_040F);
      rd(3'd2, 2'd2, v); check("R1 mask", v, 32'h0);
      see_port("R1 irq", {31'd0, irq}, 32'd0);
      see_port("R1 tx_free", {26'd0, tx_free}, 32'd32);
      rd(3'd1, 2'd2, v); check("R5 event after reset", v, 32'h0020_8900);
      wr(3'd1, 2'd2, 32'hFFFF_FFFF);
      rd(3'd1, 2'd2, v); check("R6 clear all", v, 32'h0020_0100);

      // R2 mixed-size ordering
      wr(3'd0, 2'd2, 32'h8000_040F);
      tx_put(2'd2, 32'hA1B2_C3D4, 1);
      tx_put(2'd1, 32'h1234_E5F6, 1);
      tx_put(2'd0, 32'h0000_0077, 1);
      see_port("R5 tx_free", {26'd0, tx_free}, 32'd25);
      rd(3'd1, 2'd2, v); check("R5 event counts", v, 32'h0019_0100);
      drain(7);
      rd(3'd1, 2'd2, v); check("R6 tx empty edge", v, 32'h0020_8100);

      // R3 overflow
      wr(3'd1, 2'd2, 32'hFFFF_FFFF);
      for (int i = 0; i < 8; i++) tx_put(2'd2, {8'(4*i+128), 8'(4*i+129), 8'(4*i+130), 8'(4*i+131)}, 1);
      tx_put(2'd2, 32'h1122_3344, 0);
      tx_put(2'd0, 32'h0000_0055, 0);
      see_port("R3 free stays 0", {26'd0, tx_free}, 32'd0);
      rd(3'd1, 2'd2, v); check("R3 overrun flag", v, 32'h0000_0400);
      drain(2);
      tx_put(2'd2, 32'hDEAD_BEEF, 0);
      see_port("R3 partial word dropped", {26'd0, tx_free}, 32'd2);
      tx_put(2'd1, 32'h0000_C0DE, 1);
      see_port("R3 half fits", {26'd0, tx_free}, 32'd0);
      wr(3'd1, 2'd2, 32'hFFFF_FFFF);
      drain(3);
      rd(3'd1, 2'd2, v); check("R7 tx thr below", v, 32'h0003_0100);
      drain(1);
      rd(3'd1, 2'd2, v); check("R7 tx thr reached", v, 32'h0004_0900);
      drain(28);
      tick();
      check("R2 scoreboard empty", exp_q.size(), 0);

      // R4 receive reads
      wr(3'd1, 2'd2, 32'hFFFF_FFFF);
      rx_in(8'h10); rx_in(8'h20); rx_in(8'h30);
      see_port("R5 rx_level", {26'd0, rx_level}, 32'd3);
      rd(3'd4, 2'd2, v); check("R4 short word", v, 32'h1020_3000);
      for (int i = 0; i < 5; i++) rx_in(8'(8'h41 + i));
      rd(3'd4, 2'd1, v); check("R4 half", v, 32'h0000_4142);
      rd(3'd4, 2'd0, v); check("R4 byte", v, 32'h0000_0043);
      rd(3'd4, 2'd2, v); check("R4 word tail", v, 32'h4445_0000);
      see_port("R4 rx empty", {26'd0, rx_level}, 32'd0);

      // R7 receive threshold, R8 interrupt masking
      wr(3'd0, 2'd2, 32'h8000_0402);
      wr(3'd1, 2'd2, 32'hFFFF_FFFF);
      rx_in(8'h51); rx_in(8'h52);
      rd(3'd1, 2'd2, v); check("R7 rx thr equal", v, 32'h0220_0300);
      rx_in(8'h53);
      rd(3'd1, 2'd2, v); check("R7 rx thr above", v, 32'h0320_2300);
      wr(3'd2, 2'd2, 32'h0000_2000);
      see_port("R8 irq rx thr", {31'd0, irq}, 32'd1);
      wr(3'd2, 2'd2, 32'h0000_0100);
      see_port("R8 irq live bit", {31'd0, irq}, 32'd1);
      wr(3'd2, 2'd2, 32'h0000_1000);
      see_port("R8 irq unset bit", {31'd0, irq}, 32'd0);
      wr(3'd2, 2'd2, 32'h0000_2000);
      wr(3'd1, 2'd2, 32'h0000_2000);
      see_port("R6 R8 cleared bit quiet", {31'd0, irq}, 32'd0);
      wr(3'd2, 2'd2, 32'h0);
      rd(3'd4, 2'd2, v); check("R4 three bytes", v, 32'h5152_5300);

      // R11 receive full
      wr(3'd0, 2'd2, 32'h8000_040F);
      wr(3'd1, 2'd2, 32'hFFFF_FFFF);
      for (int i = 0; i < 32; i++) rx_in(8'(i));
      rx_in(8'hEE);
      see_port("R11 level held", {26'd0, rx_level}, 32'd32);
      rd(3'd1, 2'd2, v); check("R11 full flags", v, 32'h2020_3700);
      for (int i = 0; i < 8; i++) begin
         rd(3'd4, 2'd2, v);
         check("R11 stored data", v, {8'(4*i), 8'(4*i+1), 8'(4*i+2), 8'(4*i+3)});
      end
      see_port("R11 drained", {26'd0, rx_level}, 32'd0);

      // R9 disabled engine side
      wr(3'd0, 2'd2, 32'h0000_040F);
      tx_put(2'd0, 32'h0000_005A, 1);
      see_port("R9 valid low", {31'd0, eng_tx_valid}, 32'd0);
      drain(2);
      see_port("R9 pop ignored", {26'd0, tx_free}, 32'd31);
      rx_in(8'h77);
      see_port("R9 push ignored", {26'd0, rx_level}, 32'd0);

      // R10 loopback
      wr(3'd0, 2'd2, 32'hC000_040F);
      eng_rx_push = 1'b1; eng_rx_byte = 8'h99; eng_tx_pop = 1'b1;
      tick();
      eng_rx_push = 1'b0; eng_tx_pop = 1'b0;
      see_port("R10 one byte looped", {26'd0, rx_level}, 32'd1);
      rd(3'd4, 2'd0, v); check("R10 looped value", v, 32'h0000_005A);

      // R12 done latch, R6 set beats clear
      wr(3'd0, 2'd2, 32'h8000_040F);
      wr(3'd1, 2'd2, 32'hFFFF_FFFF);
      eng_done = 1'b1; tick(); eng_done = 1'b0;
      rd(3'd1, 2'd2, v); check("R12 done bit", {31'd0, v[14]}, 32'd1);
      wr(3'd1, 2'd2, 32'h0000_4000);
      rd(3'd1, 2'd2, v); check("R6 done cleared", {31'd0, v[14]}, 32'd0);
      bus_reg = 3'd1; bus_size = 2'd2; bus_wdata = 32'h0000_4000; bus_wr = 1'b1; eng_done = 1'b1;
      tick();
      bus_wr = 1'b0; eng_done = 1'b0;
      rd(3'd1, 2'd2, v); check("R6 set wins", {31'd0, v[14]}, 32'd1);

      check("R2 final scoreboard", exp_q.size(), 0);
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule